// File: doc/BRIEF.md
# Video Address Space Translator

This block sits between a picture processor and its 14-bit video address space. Accesses to the low 8 KiB pattern region pass straight through to an external mapper port. Accesses to the nametable region are folded through a selectable mirroring arrangement onto a 2 KiB internal RAM. Accesses to the palette region land in a 32-entry internal RAM in which four background-slot entries share storage with their lower counterparts.

The requester drives an address, write data, a read strobe, a write strobe and a 3-bit mirroring mode. Writes take effect at the clock edge. Every accepted read is answered exactly one cycle later with a single-cycle `rd_valid` pulse, and this includes reads forwarded to the mapper. Addresses outside the video space and unknown mirroring modes raise `err` for one cycle.

A small response state machine tracks what the previous cycle requested. Its states are `ST_IDLE`, `ST_RESP_NT`, `ST_RESP_PAL`, `ST_RESP_EXT` and `ST_FAULT`. Every state takes the same transitions, chosen from the current strobes. An accepted read moves it to the matching `ST_RESP_*` state. A strobe to an invalid address moves it to `ST_FAULT`. Anything else returns it to `ST_IDLE`.

Top module: `vid_xlate`

## Requirements
- R1: For an address below 0x2000, a write raises `ext_wr` in the same cycle, with `ext_addr` equal to address bits 12:0 and `ext_wdata` equal to `wdata`. A read raises `ext_rd` in the same cycle and samples `ext_rdata` at the clock edge. That sampled value comes back on `rd_data` in the following cycle.
- R2: For 0x2000 to 0x3EFF, the relative value is (address − 0x2000) taken modulo 0x1000. Its bits 11:10 are the logical table and its bits 9:0 are the offset, so 0x3000 to 0x3EFF reach the same cells as 0x2000 to 0x2EFF.
- R3: The mode maps logical tables 0,1,2,3 as follows. Mode 0 gives 0,0,1,1. Mode 1 gives 0,1,0,1. Mode 2 gives 0,0,0,0. Mode 3 gives 1,1,1,1. Mode 4 gives 0,1,2,3. The physical RAM cell is ((mapped << 10) + offset) mod 2048, so mapped tables 2 and 3 fold onto 0 and 1.
- R4: For 0x3F00 to 0x3FFF, the palette index is address bits 4:0, so the palette repeats every 32 addresses.
- R5: Palette indices 0x10, 0x14, 0x18 and 0x1C use the same storage as 0x00, 0x04, 0x08 and 0x0C, for both reads and writes.
- R6: An accepted read raises `rd_valid` for exactly the next cycle, with `rd_data` valid in that cycle. `rd_valid` is low in every other cycle.
- R7: A strobe at an address of 0x4000 or above raises `err` in the next cycle. It changes neither internal RAM, raises neither `ext_rd` nor `ext_wr`, and produces no `rd_valid`.
- R8: A mode value of 5, 6 or 7 is handled as mode 4, and any strobe made under it raises `err` in the next cycle.
- R9: When `rd` and `wr` are high together, the write is performed and the read is dropped, so no `rd_valid` follows.
- R10: While reset is held and in the first cycle after it, `rd_valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| mir_mode | input | 3 | Nametable mirroring mode |
| rd_data | output | 8 | Read response data |
| rd_valid | output | 1 | Read response valid pulse |
| err | output | 1 | Invalid access or mode pulse |
| ext_addr | output | 13 | Mapper port address |
| ext_wdata | output | 8 | Mapper port write data |
| ext_rd | output | 1 | Mapper port read strobe |
| ext_wr | output | 1 | Mapper port write strobe |
| ext_rdata | input | 8 | Mapper port read data |

## Verification
Two functions can land in the same cycle. A write can arrive together with a read, either as both strobes in one cycle or as a write followed directly by a read of an aliased cell. Also, a read response can be presented in the same cycle as the next access is taken in.

The bench issues operations back to back with no idle cycles between them. It mixes in directed pairs, such as a write to palette 0x10 followed at once by a read of 0x00, and combined read-and-write strobes. Each response is judged against a bench model of both memories that is updated in the order the accesses were issued.

// File: rtl/vid_xlate_pkg.sv
package vid_xlate_pkg;

    localparam logic [31:0] NT_BASE   = 32'h0000_2000;
    localparam logic [31:0] PAL_BASE  = 32'h0000_3F00;
    localparam logic [31:0] SPACE_END = 32'h0000_4000;
    localparam logic [2:0]  MODE_MAX  = 3'd4;

    typedef enum logic [1:0] {
        RG_EXT,
        RG_NT,
        RG_PAL,
        RG_BAD
    } region_e;

    typedef enum logic [2:0] {
        MIR_PAIR_HI = 3'd0,
        MIR_PAIR_LO = 3'd1,
        MIR_SOLE_A  = 3'd2,
        MIR_SOLE_B  = 3'd3,
        MIR_FOUR    = 3'd4
    } mirror_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESP_NT,
        ST_RESP_PAL,
        ST_RESP_EXT,
        ST_FAULT
    } resp_state_e;

endpackage

// File: rtl/vid_xlate_decode.sv
module vid_xlate_decode
    import vid_xlate_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NT_AW  = 11,
    parameter int PAL_AW = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        mir_mode,
    output region_e           region,
    output logic [NT_AW-1:0]  nt_idx,
    output logic [PAL_AW-1:0] pal_idx,
    output logic              mode_bad
);

    localparam int OFF_W = 10;

    logic [11:0]      nt_rel;
    logic [1:0]       log_tbl;
    logic [1:0]       phys_tbl;
    mirror_e          eff_mode;
    logic [PAL_AW-1:0] pal_raw;

    always_comb begin
        if (addr < ADDR_W'(NT_BASE))
            region = RG_EXT;
        else if (addr < ADDR_W'(PAL_BASE))
            region = RG_NT;
        else if (addr < ADDR_W'(SPACE_END))
            region = RG_PAL;
        else
            region = RG_BAD;
    end

    assign mode_bad = (mir_mode > MODE_MAX);
    assign eff_mode = mode_bad ? MIR_FOUR : mirror_e'(mir_mode);

    assign nt_rel  = addr[11:0] - NT_BASE[11:0];
    assign log_tbl = nt_rel[11:10];

    always_comb begin
        unique case (eff_mode)
            MIR_PAIR_HI: phys_tbl = {1'b0, log_tbl[1]};
            MIR_PAIR_LO: phys_tbl = {1'b0, log_tbl[0]};
            MIR_SOLE_A:  phys_tbl = 2'd0;
            MIR_SOLE_B:  phys_tbl = 2'd1;
            default:     phys_tbl = log_tbl;
        endcase
    end

    assign nt_idx = NT_AW'({phys_tbl, nt_rel[OFF_W-1:0]});

    assign pal_raw = addr[PAL_AW-1:0];
    always_comb begin
        if (pal_raw[PAL_AW-1] && (pal_raw[1:0] == 2'b00))
            pal_idx = {1'b0, pal_raw[PAL_AW-2:0]};
        else
            pal_idx = pal_raw;
    end

endmodule

// File: rtl/vid_xlate_ram.sv
module vid_xlate_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we)
                mem[a] <= d;
            else
                q <= mem[a];
        end
    end

endmodule

// File: rtl/vid_xlate_ctrl.sv
module vid_xlate_ctrl
    import vid_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd,
    input  logic        wr,
    input  region_e     region,
    input  logic        mode_bad,
    output logic        nt_en,
    output logic        nt_we,
    output logic        pal_en,
    output logic        pal_we,
    output logic        ext_rd,
    output logic        ext_wr,
    output logic        ext_cap,
    output resp_state_e state,
    output logic        rd_valid,
    output logic        err
);

    resp_state_e state_d;
    logic        mode_err_q;
    logic        rd_only;

    assign rd_only = rd && !wr;

    always_comb begin
        state_d = ST_IDLE;
        if ((rd || wr) && region == RG_BAD)
            state_d = ST_FAULT;
        else if (rd_only) begin
            unique case (region)
                RG_EXT:  state_d = ST_RESP_EXT;
                RG_NT:   state_d = ST_RESP_NT;
                RG_PAL:  state_d = ST_RESP_PAL;
                default: state_d = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mode_err_q <= 1'b0;
        end else begin
            state      <= state_d;
            mode_err_q <= (rd || wr) && mode_bad;
        end
    end

    always_comb begin
        nt_en   = (rd_only || wr) && region == RG_NT;
        nt_we   = wr && region == RG_NT;
        pal_en  = (rd_only || wr) && region == RG_PAL;
        pal_we  = wr && region == RG_PAL;
        ext_wr  = wr && region == RG_EXT;
        ext_rd  = rd_only && region == RG_EXT;
        ext_cap = ext_rd;
        unique case (state)
            ST_RESP_NT, ST_RESP_PAL, ST_RESP_EXT: begin
                rd_valid = 1'b1;
                err      = mode_err_q;
            end
            ST_FAULT: begin
                rd_valid = 1'b0;
                err      = 1'b1;
            end
            default: begin
                rd_valid = 1'b0;
                err      = mode_err_q;
            end
        endcase
    end

    a_r6_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && region != RG_BAD) |=> rd_valid);

    a_r6_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_only));

    a_r7_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd || wr) && region == RG_BAD) |=> (err && !rd_valid));

    a_r7_no_ext_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (region != RG_EXT) |-> !(ext_rd || ext_wr));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wr) |=> !rd_valid);

endmodule

// File: rtl/vid_xlate.sv
module vid_xlate
    import vid_xlate_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int NT_AW  = 11,
    parameter int PAL_AW = 5,
    parameter int EXT_AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    input  logic [2:0]        mir_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_rd,
    output logic              ext_wr,
    input  logic [DATA_W-1:0] ext_rdata
);

    region_e           region;
    logic [NT_AW-1:0]  nt_idx;
    logic [PAL_AW-1:0] pal_idx;
    logic              mode_bad;
    logic              nt_en, nt_we, pal_en, pal_we, ext_cap;
    resp_state_e       state;
    logic [DATA_W-1:0] nt_q, pal_q, ext_q;

    vid_xlate_decode #(
        .ADDR_W(ADDR_W), .NT_AW(NT_AW), .PAL_AW(PAL_AW)
    ) u_decode (
        .addr(addr), .mir_mode(mir_mode), .region(region),
        .nt_idx(nt_idx), .pal_idx(pal_idx), .mode_bad(mode_bad)
    );

    vid_xlate_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr),
        .region(region), .mode_bad(mode_bad),
        .nt_en(nt_en), .nt_we(nt_we), .pal_en(pal_en), .pal_we(pal_we),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_cap(ext_cap),
        .state(state), .rd_valid(rd_valid), .err(err)
    );

    vid_xlate_ram #(.AW(NT_AW), .DW(DATA_W)) u_nt_ram (
        .clk(clk), .en(nt_en), .we(nt_we), .a(nt_idx), .d(wdata), .q(nt_q)
    );

    vid_xlate_ram #(.AW(PAL_AW), .DW(DATA_W)) u_pal_ram (
        .clk(clk), .en(pal_en), .we(pal_we), .a(pal_idx), .d(wdata), .q(pal_q)
    );

    assign ext_addr  = addr[EXT_AW-1:0];
    assign ext_wdata = wdata;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_q <= '0;
        else if (ext_cap)
            ext_q <= ext_rdata;
    end

    always_comb begin
        unique case (state)
            ST_RESP_NT:  rd_data = nt_q;
            ST_RESP_PAL: rd_data = pal_q;
            ST_RESP_EXT: rd_data = ext_q;
            default:     rd_data = '0;
        endcase
    end

    a_r8_mode_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd || wr) && mir_mode > 3'd4) |=> err);

    a_r1_ext_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd |=> (rd_valid && rd_data == $past(ext_rdata)));

endmodule

// File: tb/vid_xlate_bench.sv
module vid_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [2:0]  mir_mode = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, err;
    logic [12:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic        ext_rd, ext_wr;
    logic [7:0]  ext_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] nt_m  [2048];
    logic [7:0] pal_m [32];

    always #4 clk = ~clk;

    vid_xlate u_vid_xlate (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
        .mir_mode(mir_mode), .rd_data(rd_data), .rd_valid(rd_valid), .err(err),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rd(ext_rd),
        .ext_wr(ext_wr), .ext_rdata(ext_rdata)
    );

    function automatic logic [7:0] ext_model(logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'hA5;
    endfunction

    assign ext_rdata = ext_model(ext_addr);

    function automatic int nt_phys(logic [15:0] a, logic [2:0] m);
        int rel, t, mt, mm;
        rel = (int'(a) - 'h2000) % 'h1000;
        t   = rel / 1024;
        mm  = (m > 4) ? 4 : int'(m);
        case (mm)
            0: mt = t / 2;
            1: mt = t % 2;
            2: mt = 0;
            3: mt = 1;
            default: mt = t;
        endcase
        return ((mt * 1024) + (rel % 1024)) % 2048;
    endfunction

    function automatic int pal_phys(logic [15:0] a);
        int i;
        i = int'(a) % 32;
        if (i >= 16 && (i % 4) == 0) i = i - 16;
        return i;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_op(bit r, bit w, logic [15:0] a, logic [7:0] d, logic [2:0] m);
        bit is_ext, inval, exp_v, exp_e;
        int exp_d;
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d; mir_mode = m;
        is_ext = (a < 16'h2000);
        inval  = (a >= 16'h4000);
        #1;
        check("R1/R7 ext_wr", int'(ext_wr), int'(w && is_ext));
        check("R1/R7/R9 ext_rd", int'(ext_rd), int'(r && !w && is_ext));
        if ((r || w) && is_ext) check("R1 ext_addr", int'(ext_addr), int'(a[12:0]));
        if (w && is_ext) check("R1 ext_wdata", int'(ext_wdata), int'(d));
        exp_v = r && !w && !inval;
        exp_e = (r || w) && (inval || m > 3'd4);
        exp_d = 0;
        if (exp_v) begin
            if (is_ext) exp_d = int'(ext_model(a[12:0]));
            else if (a < 16'h3F00) exp_d = int'(nt_m[nt_phys(a, m)]);
            else exp_d = int'(pal_m[pal_phys(a)]);
        end
        if (w && !inval && !is_ext) begin
            if (a < 16'h3F00) nt_m[nt_phys(a, m)] = d;
            else pal_m[pal_phys(a)] = d;
        end
        @(posedge clk);
        #1;
        check("R6/R9 rd_valid", int'(rd_valid), int'(exp_v));
        check("R7/R8 err", int'(err), int'(exp_e));
        if (exp_v) check("R2/R3/R4/R5 rd_data", int'(rd_data), exp_d);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed, k, op, mi;
        logic [15:0] a;
        logic [2:0]  m;
        bit r, w;
        seed = int'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset rd_valid", int'(rd_valid), 0);
        check("R10 reset err", int'(err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 post-reset rd_valid", int'(rd_valid), 0);
        check("R10 post-reset err", int'(err), 0);

        for (int i = 0; i < 2048; i++)
            do_op(1'b0, 1'b1, 16'h2000 + 16'(i), 8'($urandom), 3'd4);
        for (int i = 0; i < 32; i++)
            do_op(1'b0, 1'b1, 16'h3F00 + 16'(i), 8'($urandom), 3'd0);

        // R5 aliasing, write then immediate read of partner
        do_op(1'b0, 1'b1, 16'h3F10, 8'h3C, 3'd0);
        do_op(1'b1, 1'b0, 16'h3F00, 8'h00, 3'd0);
        do_op(1'b0, 1'b1, 16'h3F0C, 8'h71, 3'd0);
        do_op(1'b1, 1'b0, 16'h3F1C, 8'h00, 3'd0);
        do_op(1'b1, 1'b0, 16'h3F11, 8'h00, 3'd0);
        // R4 repetition
        do_op(1'b1, 1'b0, 16'h3FE5, 8'h00, 3'd0);
        // R2 upper mirror
        do_op(1'b0, 1'b1, 16'h3005, 8'h9E, 3'd1);
        do_op(1'b1, 1'b0, 16'h2005, 8'h00, 3'd1);
        // R3 each mode, same cell through different tables
        for (int md = 0; md < 5; md++) begin
            do_op(1'b0, 1'b1, 16'h2C37, 8'(8'h40 + md), 3'(md));
            do_op(1'b1, 1'b0, 16'h2437, 8'h00, 3'(md));
            do_op(1'b1, 1'b0, 16'h2837, 8'h00, 3'(md));
        end
        // R7 invalid write must not alias onto 0x2123
        do_op(1'b0, 1'b1, 16'h6123, 8'hEE, 3'd4);
        do_op(1'b1, 1'b0, 16'h2123, 8'h00, 3'd4);
        do_op(1'b1, 1'b0, 16'hC000, 8'h00, 3'd4);
        // R8 mode above 4
        do_op(1'b1, 1'b0, 16'h2C00, 8'h00, 3'd6);
        // R9 combined strobes
        do_op(1'b1, 1'b1, 16'h3F02, 8'h5D, 3'd0);
        do_op(1'b1, 1'b0, 16'h3F02, 8'h00, 3'd0);
        do_op(1'b1, 1'b1, 16'h0123, 8'h11, 3'd0);
        // R1 external read
        do_op(1'b1, 1'b0, 16'h1ABC, 8'h00, 3'd0);

        for (int n = 0; n < 4000; n++) begin
            k  = int'($urandom % 10);
            op = int'($urandom % 20);
            mi = int'($urandom % 10);
            if (k < 3) a = 16'($urandom % 'h2000);
            else if (k < 7) a = 16'h2000 + 16'($urandom % 'h1F00);
            else if (k < 9) a = 16'h3F00 + 16'($urandom % 'h100);
            else a = 16'h4000 + 16'($urandom % 'hC000);
            m = (mi < 8) ? 3'($urandom % 5) : 3'(5 + ($urandom % 3));
            r = (op < 10) || (op == 18);
            w = (op >= 10 && op < 18) || (op == 18);
            do_op(r, w, a, 8'($urandom), m);
        end
        do_op(1'b0, 1'b0, 16'h0000, 8'h00, 3'd0);

        done = 1'b1;
        if (seed == -1) $display("seed wrap");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule